// File: doc/BRIEF.md
# Load/Store Data Formatting Unit

This block sits between the register file and the data memory port of a 64-bit core whose memory is big-endian. It is purely combinational. For a load it takes the raw doubleword returned by memory, the low three bits of the effective address and the 10-bit extended opcode. From these it builds the value written back to the register: a byte, halfword, word or doubleword that is zero-extended, sign-extended or byte-reversed. For a store it takes the source register value and places the selected low-order bytes into the addressed memory byte lanes. When the opcode asks for it, the bytes are reversed first. It also produces the matching byte-enable mask.

The opcode alone picks the access size, the kind of extension and whether the bytes are reversed. Reversed accesses go through the same lane-selection and extension path as plain ones. Load-and-reserve opcodes are formatted exactly like plain loads. Any reservation tracking lives elsewhere. An opcode outside the supported set is flagged as illegal, and every data and enable output is then zero. Address generation, the memory handshake, floating-point conversion and alignment traps belong to other blocks.

Top module: `lsfmt_top`

## Requirements
- R1: Opcodes 87, 279, 23 and 21 load the byte, halfword, word and doubleword at the addressed offset, with the upper result bits cleared.
- R2: Opcode 343 loads a halfword and opcode 341 loads a word. Both copy the most significant bit of the loaded field into every higher result bit.
- R3: Reserve-type loads 52, 116, 20 and 84 give the same byte, halfword, word and doubleword results as the plain zero-extending loads.
- R4: Opcodes 790, 534 and 532 load a halfword, word and doubleword with the byte order inside the field reversed. The halfword and word results have their upper bits cleared.
- R5: Opcodes 215, 407, 151 and 149 store the least significant 1, 2, 4 and 8 bytes of `reg_wdata`. The most significant of these bytes goes to the addressed offset, and all other lanes of `st_data` are zero.
- R6: Opcodes 918, 662 and 660 store 2, 4 and 8 bytes with their order reversed, so that the least significant register byte lands at the addressed offset.
- R7: For a store, bit k of `st_byte_en` is set exactly for the bytes at offsets covered by the access. For a load or an illegal opcode, the mask is zero.
- R8: Byte offset k of the doubleword occupies bits [63-8k : 56-8k], so offset 0 is the most significant byte. Offset bits below the access size are ignored: the access is aligned down.
- R9: Any other opcode value raises `illegal` and drives zero on `ld_result`, `st_data`, `st_byte_en`, `is_load` and `is_store`.
- R10: `is_load` and `is_store` mark the operation class. A load drives zero on the store outputs, and a store drives zero on `ld_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_xo | input | 10 | Extended opcode selecting the operation |
| addr_ofs | input | 3 | Low effective-address bits, the byte offset in the doubleword |
| mem_rdata | input | 64 | Raw doubleword read from memory |
| reg_wdata | input | 64 | Source register value for stores |
| ld_result | output | 64 | Formatted load result for the register file |
| st_data | output | 64 | Store data placed in memory byte lanes |
| st_byte_en | output | 8 | Byte enables, bit k for offset k |
| is_load | output | 1 | Opcode is a supported load |
| is_store | output | 1 | Opcode is a supported store |
| illegal | output | 1 | Opcode is not supported |

## Verification
The checks assume that the inputs are settled two-state values whenever they are sampled. They also assume that the offset is the real low part of an address, so the aligned-down access always fits inside the doubleword. Under those assumptions the properties must hold for every opcode, including unused ones. The stimulus drives inputs only shortly after a clock edge and compares results half a cycle later. It sweeps every supported opcode over all eight offsets, misaligned ones included, with random data. Illegal values are taken from the gaps around and between the legal codes.

// File: rtl/lsfmt_pkg.sv
package lsfmt_pkg;

    localparam int DW     = 64;
    localparam int NB     = DW / 8;
    localparam int OFS_W  = $clog2(NB);
    localparam int OPC_W  = 10;
    localparam int BIT_W  = $clog2(DW);

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        acc_size_e size;
        logic      sext;
        logic      swap;
    } acc_ctrl_t;

    // Load opcodes
    localparam logic [OPC_W-1:0] XO_LB_Z   = 10'd87;
    localparam logic [OPC_W-1:0] XO_LH_Z   = 10'd279;
    localparam logic [OPC_W-1:0] XO_LW_Z   = 10'd23;
    localparam logic [OPC_W-1:0] XO_LD     = 10'd21;
    localparam logic [OPC_W-1:0] XO_LH_S   = 10'd343;
    localparam logic [OPC_W-1:0] XO_LW_S   = 10'd341;
    localparam logic [OPC_W-1:0] XO_LB_RSV = 10'd52;
    localparam logic [OPC_W-1:0] XO_LH_RSV = 10'd116;
    localparam logic [OPC_W-1:0] XO_LW_RSV = 10'd20;
    localparam logic [OPC_W-1:0] XO_LD_RSV = 10'd84;
    localparam logic [OPC_W-1:0] XO_LH_REV = 10'd790;
    localparam logic [OPC_W-1:0] XO_LW_REV = 10'd534;
    localparam logic [OPC_W-1:0] XO_LD_REV = 10'd532;
    // Store opcodes
    localparam logic [OPC_W-1:0] XO_SB     = 10'd215;
    localparam logic [OPC_W-1:0] XO_SH     = 10'd407;
    localparam logic [OPC_W-1:0] XO_SW     = 10'd151;
    localparam logic [OPC_W-1:0] XO_SD     = 10'd149;
    localparam logic [OPC_W-1:0] XO_SH_REV = 10'd918;
    localparam logic [OPC_W-1:0] XO_SW_REV = 10'd662;
    localparam logic [OPC_W-1:0] XO_SD_REV = 10'd660;

    function automatic int size_bytes(acc_size_e s);
        return 1 << s;
    endfunction

    // Clear offset bits below the access size
    function automatic logic [OFS_W-1:0] align_offset(logic [OFS_W-1:0] ofs, acc_size_e s);
        logic [OFS_W-1:0] low;
        low = OFS_W'((1 << s) - 1);
        return ofs & ~low;
    endfunction

    // Bit distance from the least significant end to the accessed field
    function automatic int field_shift(logic [OFS_W-1:0] ofs, acc_size_e s);
        return 8 * (NB - int'(align_offset(ofs, s)) - size_bytes(s));
    endfunction

    // Reverse the low n bytes of a value; upper bytes become zero
    function automatic logic [DW-1:0] byte_reverse(logic [DW-1:0] d, acc_size_e s);
        logic [DW-1:0] r;
        int n;
        n = size_bytes(s);
        r = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < n) begin
                r[8*i +: 8] = d[8*(n-1-i) +: 8];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lsfmt_decode.sv
module lsfmt_decode
    import lsfmt_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output acc_ctrl_t        ctrl
);

    always_comb begin
        ctrl = '{kind: K_NONE, size: SZ_BYTE, sext: 1'b0, swap: 1'b0};
        case (opc)
            XO_LB_Z, XO_LB_RSV: ctrl = '{kind: K_LOAD, size: SZ_BYTE,   sext: 1'b0, swap: 1'b0};
            XO_LH_Z, XO_LH_RSV: ctrl = '{kind: K_LOAD, size: SZ_HALF,   sext: 1'b0, swap: 1'b0};
            XO_LW_Z, XO_LW_RSV: ctrl = '{kind: K_LOAD, size: SZ_WORD,   sext: 1'b0, swap: 1'b0};
            XO_LD,   XO_LD_RSV: ctrl = '{kind: K_LOAD, size: SZ_DOUBLE, sext: 1'b0, swap: 1'b0};
            XO_LH_S:            ctrl = '{kind: K_LOAD, size: SZ_HALF,   sext: 1'b1, swap: 1'b0};
            XO_LW_S:            ctrl = '{kind: K_LOAD, size: SZ_WORD,   sext: 1'b1, swap: 1'b0};
            XO_LH_REV:          ctrl = '{kind: K_LOAD, size: SZ_HALF,   sext: 1'b0, swap: 1'b1};
            XO_LW_REV:          ctrl = '{kind: K_LOAD, size: SZ_WORD,   sext: 1'b0, swap: 1'b1};
            XO_LD_REV:          ctrl = '{kind: K_LOAD, size: SZ_DOUBLE, sext: 1'b0, swap: 1'b1};
            XO_SB:              ctrl = '{kind: K_STORE, size: SZ_BYTE,   sext: 1'b0, swap: 1'b0};
            XO_SH:              ctrl = '{kind: K_STORE, size: SZ_HALF,   sext: 1'b0, swap: 1'b0};
            XO_SW:              ctrl = '{kind: K_STORE, size: SZ_WORD,   sext: 1'b0, swap: 1'b0};
            XO_SD:              ctrl = '{kind: K_STORE, size: SZ_DOUBLE, sext: 1'b0, swap: 1'b0};
            XO_SH_REV:          ctrl = '{kind: K_STORE, size: SZ_HALF,   sext: 1'b0, swap: 1'b1};
            XO_SW_REV:          ctrl = '{kind: K_STORE, size: SZ_WORD,   sext: 1'b0, swap: 1'b1};
            XO_SD_REV:          ctrl = '{kind: K_STORE, size: SZ_DOUBLE, sext: 1'b0, swap: 1'b1};
            default:            ctrl = '{kind: K_NONE, size: SZ_BYTE,   sext: 1'b0, swap: 1'b0};
        endcase
    end

endmodule

// File: rtl/lsfmt_lane_mask.sv
module lsfmt_lane_mask
    import lsfmt_pkg::*;
(
    input  acc_size_e         size,
    output logic [DW-1:0]     keep_bits
);

    // Bit mask covering the low size_bytes(size) bytes
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign keep_bits[8*g +: 8] = {8{(g < size_bytes(size))}};
    end

endmodule

// File: rtl/lsfmt_load_fmt.sv
module lsfmt_load_fmt
    import lsfmt_pkg::*;
(
    input  logic                en,
    input  acc_size_e           size,
    input  logic                sext,
    input  logic                swap,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [DW-1:0]       keep_bits,
    input  logic [DW-1:0]       mem,
    output logic [DW-1:0]       result
);

    logic [DW-1:0] field;
    logic [DW-1:0] ordered;
    logic          msb;

    always_comb begin
        field   = (mem >> field_shift(ofs, size)) & keep_bits;
        ordered = swap ? byte_reverse(field, size) : field;
        msb     = ordered[BIT_W'(8 * size_bytes(size) - 1)];
        if (!en) begin
            result = '0;
        end else if (sext && msb) begin
            result = ordered | ~keep_bits;
        end else begin
            result = ordered;
        end
    end

endmodule

// File: rtl/lsfmt_store_fmt.sv
module lsfmt_store_fmt
    import lsfmt_pkg::*;
(
    input  logic                en,
    input  acc_size_e           size,
    input  logic                swap,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [DW-1:0]       keep_bits,
    input  logic [DW-1:0]       src,
    output logic [DW-1:0]       data,
    output logic [NB-1:0]       byte_en
);

    logic [DW-1:0]    low_part;
    logic [DW-1:0]    ordered;
    logic [OFS_W-1:0] base;
    logic [NB-1:0]    lanes;

    always_comb begin
        low_part = src & keep_bits;
        ordered  = swap ? byte_reverse(low_part, size) : low_part;
        base     = align_offset(ofs, size);
    end

    // Lane k is offset k; enable the offsets the access covers
    for (genvar k = 0; k < NB; k++) begin : g_be
        assign lanes[k] = (k >= int'(base)) && (k < int'(base) + size_bytes(size));
    end

    assign data    = en ? (ordered << field_shift(ofs, size)) : '0;
    assign byte_en = en ? lanes : '0;

endmodule

// File: rtl/lsfmt_top.sv
module lsfmt_top
    import lsfmt_pkg::*;
(
    input  logic [OPC_W-1:0] op_xo,
    input  logic [OFS_W-1:0] addr_ofs,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    ld_result,
    output logic [DW-1:0]    st_data,
    output logic [NB-1:0]    st_byte_en,
    output logic             is_load,
    output logic             is_store,
    output logic             illegal
);

    acc_ctrl_t     ctrl;
    logic [DW-1:0] keep_bits;

    lsfmt_decode u_decode (
        .opc  (op_xo),
        .ctrl (ctrl)
    );

    lsfmt_lane_mask u_mask (
        .size      (ctrl.size),
        .keep_bits (keep_bits)
    );

    lsfmt_load_fmt u_load (
        .en        (ctrl.kind == K_LOAD),
        .size      (ctrl.size),
        .sext      (ctrl.sext),
        .swap      (ctrl.swap),
        .ofs       (addr_ofs),
        .keep_bits (keep_bits),
        .mem       (mem_rdata),
        .result    (ld_result)
    );

    lsfmt_store_fmt u_store (
        .en        (ctrl.kind == K_STORE),
        .size      (ctrl.size),
        .swap      (ctrl.swap),
        .ofs       (addr_ofs),
        .keep_bits (keep_bits),
        .src       (reg_wdata),
        .data      (st_data),
        .byte_en   (st_byte_en)
    );

    assign is_load  = (ctrl.kind == K_LOAD);
    assign is_store = (ctrl.kind == K_STORE);
    assign illegal  = (ctrl.kind == K_NONE);

endmodule

// File: rtl/lsfmt_checker.sv
module lsfmt_checker
    import lsfmt_pkg::*;
(
    input logic [DW-1:0] ld_result,
    input logic [DW-1:0] st_data,
    input logic [NB-1:0] st_byte_en,
    input logic          is_load,
    input logic          is_store,
    input logic          illegal
);

    logic [DW-1:0] en_bits;

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            en_bits[DW-1-8*k -: 8] = {8{st_byte_en[k]}};
        end
    end

    always_comb begin
        AST_ONE_CLASS: assert ($onehot({is_load, is_store, illegal})) else $error("class flags not one-hot"); // R10
        AST_ILLEGAL_QUIET: assert (!illegal || (ld_result == '0 && st_data == '0 && st_byte_en == '0)) else $error("illegal opcode drove data"); // R9
        AST_LOAD_NO_WRITE: assert (!is_load || (st_byte_en == '0 && st_data == '0)) else $error("load drove store outputs"); // R10
        AST_STORE_NO_RESULT: assert (!is_store || ld_result == '0) else $error("store drove load result"); // R10
        AST_STORE_SIZE: assert (!is_store || ($countones(st_byte_en) inside {1, 2, 4, 8})) else $error("store enable count not a size"); // R7
        AST_DATA_IN_LANES: assert ((st_data & ~en_bits) == '0) else $error("store data outside enabled lanes"); // R8
    end

endmodule

bind lsfmt_top lsfmt_checker u_checker (
    .ld_result  (ld_result),
    .st_data    (st_data),
    .st_byte_en (st_byte_en),
    .is_load    (is_load),
    .is_store   (is_store),
    .illegal    (illegal)
);

// File: tb/tb_lsfmt_top.sv
`timescale 1ns/1ps
module tb_lsfmt_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  op_xo = '0;
    logic [2:0]  addr_ofs = '0;
    logic [63:0] mem_rdata = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] ld_result;
    logic [63:0] st_data;
    logic [7:0]  st_byte_en;
    logic        is_load, is_store, illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    lsfmt_top dut (
        .op_xo(op_xo), .addr_ofs(addr_ofs), .mem_rdata(mem_rdata), .reg_wdata(reg_wdata),
        .ld_result(ld_result), .st_data(st_data), .st_byte_en(st_byte_en),
        .is_load(is_load), .is_store(is_store), .illegal(illegal)
    );

    typedef struct {
        string       tag;
        logic [9:0]  opc;
        logic [63:0] ld;
        logic [63:0] sd;
        logic [7:0]  be;
        logic [2:0]  cls;  // {illegal, is_store, is_load}
    } exp_t;

    exp_t sb_q[$];

    // Reference: kind 0 none, 1 load, 2 store; n bytes; sign; reverse
    task automatic ref_item(input logic [9:0] opc, input logic [2:0] ofs,
                            input logic [63:0] mem, input logic [63:0] rd,
                            input string tag_in, output exp_t e);
        int kind, n, o;
        bit sgn, rev;
        logic [7:0] m [8];
        logic [63:0] v;
        string tg;
        kind = 0; n = 1; sgn = 0; rev = 0; tg = "R9";
        case (opc)
            10'd87:  begin kind = 1; n = 1; tg = "R1"; end
            10'd279: begin kind = 1; n = 2; tg = "R1"; end
            10'd23:  begin kind = 1; n = 4; tg = "R1"; end
            10'd21:  begin kind = 1; n = 8; tg = "R1"; end
            10'd343: begin kind = 1; n = 2; sgn = 1; tg = "R2"; end
            10'd341: begin kind = 1; n = 4; sgn = 1; tg = "R2"; end
            10'd52:  begin kind = 1; n = 1; tg = "R3"; end
            10'd116: begin kind = 1; n = 2; tg = "R3"; end
            10'd20:  begin kind = 1; n = 4; tg = "R3"; end
            10'd84:  begin kind = 1; n = 8; tg = "R3"; end
            10'd790: begin kind = 1; n = 2; rev = 1; tg = "R4"; end
            10'd534: begin kind = 1; n = 4; rev = 1; tg = "R4"; end
            10'd532: begin kind = 1; n = 8; rev = 1; tg = "R4"; end
            10'd215: begin kind = 2; n = 1; tg = "R5"; end
            10'd407: begin kind = 2; n = 2; tg = "R5"; end
            10'd151: begin kind = 2; n = 4; tg = "R5"; end
            10'd149: begin kind = 2; n = 8; tg = "R5"; end
            10'd918: begin kind = 2; n = 2; rev = 1; tg = "R6"; end
            10'd662: begin kind = 2; n = 4; rev = 1; tg = "R6"; end
            10'd660: begin kind = 2; n = 8; rev = 1; tg = "R6"; end
            default: kind = 0;
        endcase
        if (tag_in != "") tg = tag_in;
        for (int k = 0; k < 8; k++) m[k] = mem[63-8*k -: 8];
        o = int'(ofs) - (int'(ofs) % n);  // R8 align down
        e.tag = tg; e.opc = opc; e.ld = '0; e.sd = '0; e.be = '0;
        e.cls = (kind == 1) ? 3'b001 : (kind == 2) ? 3'b010 : 3'b100;
        if (kind == 1) begin
            v = '0;
            for (int i = 0; i < n; i++) begin
                if (rev) v = v | (64'(m[o+i]) << (8*i));
                else     v = (v << 8) | 64'(m[o+i]);
            end
            if (sgn && v[8*n-1]) begin
                for (int b = 8*n; b < 64; b++) v[b] = 1'b1;
            end
            e.ld = v;
        end else if (kind == 2) begin
            for (int i = 0; i < n; i++) begin
                e.be[o+i] = 1'b1;
                if (rev) e.sd[63-8*(o+i) -: 8] = rd[8*i +: 8];
                else     e.sd[63-8*(o+i) -: 8] = rd[8*(n-1-i) +: 8];
            end
        end
    endtask

    task automatic drive(input logic [9:0] opc, input logic [2:0] ofs,
                         input logic [63:0] mem, input logic [63:0] rd, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        op_xo = opc; addr_ofs = ofs; mem_rdata = mem; reg_wdata = rd;
        ref_item(opc, ofs, mem, rd, tag, e);
        sb_q.push_back(e);
    endtask

    // Monitor: compare half a cycle after each drive
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (ld_result !== e.ld || st_data !== e.sd || st_byte_en !== e.be ||
                {illegal, is_store, is_load} !== e.cls) begin
                n_fails++;
                $display("FAIL %s opc=%0d: actual ld=%h sd=%h be=%b cls=%b expected ld=%h sd=%h be=%b cls=%b",
                         e.tag, e.opc, ld_result, st_data, st_byte_en, {illegal, is_store, is_load},
                         e.ld, e.sd, e.be, e.cls);
            end
        end
    end

    int legal_ops [20] = '{87, 279, 23, 21, 343, 341, 52, 116, 20, 84,
                           790, 534, 532, 215, 407, 151, 149, 918, 662, 660};
    int bad_ops [10] = '{0, 1, 22, 88, 150, 535, 599, 661, 919, 1023};

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: opcode 0 idle, everything quiet (R9)
        drive(10'd0, 3'd0, 64'h0, 64'h0, "R9_reset");
        // R8 lane order with a known pattern
        drive(10'd87,  3'd0, 64'h0123456789ABCDEF, 64'h0, "R8");  // 0x01
        drive(10'd87,  3'd7, 64'h0123456789ABCDEF, 64'h0, "R8");  // 0xEF
        drive(10'd279, 3'd3, 64'h0123456789ABCDEF, 64'h0, "R8");  // aligned to 2: 0x4567
        drive(10'd23,  3'd6, 64'h0123456789ABCDEF, 64'h0, "R8");  // aligned to 4: 0x89ABCDEF
        // R2 sign bit set and clear
        drive(10'd343, 3'd0, 64'h8001_0000_0000_0000, 64'h0, "R2");
        drive(10'd341, 3'd4, 64'h0000_0000_7FFF_FFFF, 64'h0, "R2");
        // R4 reversed halfword
        drive(10'd790, 3'd2, 64'h0000_A1B2_0000_0000, 64'h0, "R4");
        // R7 enables at each store size
        drive(10'd215, 3'd5, 64'h0, 64'h1122334455667788, "R7");
        drive(10'd151, 3'd4, 64'h0, 64'h1122334455667788, "R7");
        drive(10'd660, 3'd0, 64'h0, 64'h1122334455667788, "R6");
        // R10 store with memory data present, load with register data present
        drive(10'd149, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0BAD_F00D, "R10");
        drive(10'd21,  3'd0, 64'hCAFE_F00D_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        // Sweep every legal opcode over all offsets with random data
        for (int p = 0; p < 20; p++) begin
            for (int ofs = 0; ofs < 8; ofs++) begin
                for (int r = 0; r < 3; r++) begin
                    drive(10'(legal_ops[p]), 3'(ofs), {$urandom, $urandom}, {$urandom, $urandom}, "");
                end
            end
        end
        // R9 illegal opcodes with busy inputs
        for (int p = 0; p < 10; p++) begin
            drive(10'(bad_ops[p]), 3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom}, "R9");
        end
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule